// File: doc/BRIEF.md
# Linked-List DMA Descriptor Autoloader

This block drives one DMA channel through a chain of descriptors stored in memory. Each descriptor carries a fresh set of channel configuration values. The block reads a descriptor word by word into the channel's configuration slots and then tells an external transfer engine to run. When the engine reports completion, the block follows the link to the next descriptor and repeats, with no processor help until the end of the chain. The transfer engine that moves the data sits outside the block. The engine samples the configuration slots when the block starts it.

Software programs the block through a small register port. It sets the first-descriptor address, optionally presets the configuration slots, and writes a control word that selects chain mode, fast mode, descriptor format and pause-interrupt masking, together with a start bit. Three descriptor formats reload different subsets of the slots. A per-descriptor pause flag parks the channel after that descriptor is loaded, and a resume write from software releases it. A sticky interrupt is raised at the end of the whole chain, and can also be raised at each pause.

Top module: `dma_desc_autoload`

## Requirements
- R1: After reset the status reads state idle (code 0), irq_o is 0, mem_req_o is 0 and xe_start_o is 0.
- R2: With control bit 8 (list) clear, a start runs exactly one transfer with the current slot values and then enters done.
- R3: With list set and control bit 10 (fast) clear, the first transfer uses the slots as already programmed, and the descriptor at the head pointer (register 1) is fetched only after that transfer completes.
- R4: With list and fast set, the head descriptor is loaded before the first transfer starts.
- R5: Control bits 5:4 select the format. 01 gives 8 words, which update slots 0..6. 10 gives 5 words, which update slots 0..3. 11 and 00 give 3 words, which update slots 0..1. Word k+1 goes to slot k. Words are read from consecutive addresses starting at the descriptor address, in order, one read outstanding at a time.
- R6: A slot that a descriptor does not rewrite keeps its value. Slot 0 (source) is written only if word-0 bit 24 is set, and slot 1 (destination) only if word-0 bit 26 is set.
- R7: The next descriptor address is word-0 bits [AW+7:8]. After the transfer of a descriptor whose word-0 bit 28 is set, the channel enters done.
- R8: A descriptor with word-0 bit 0 set is loaded but not started, and the status shows paused (code 2). Writing control bit 1 (resume) then starts the transfer with the loaded slots. A resume in any other state is ignored.
- R9: The slot outputs do not change while a transfer runs or while the channel is paused.
- R10: Entering done (code 4) sets status bit 4 and irq_o once per run. Writing 1 to status bit 4 clears it and returns the channel to idle.
- R11: With control bit 12 set, each pause sets status bit 4+1 and irq_o. Writing 1 to that bit clears it.
- R12: A start, a control-field write, a head write or a slot write (registers 8..14) made while the channel is not idle has no effect.
- R13: Status bits [2:0] give the state: idle 0, fetch 1, paused 2, transfer 3, done 4. Bits [16+AW-1:16] give the address of the descriptor in use. Register 0 is control, 1 is head and 2 is status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational on reg_addr_i |
| mem_req_o | output | 1 | Descriptor read request valid |
| mem_addr_o | output | AW | Descriptor word address |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| xe_start_o | output | 1 | One-cycle start pulse to the transfer engine |
| xe_done_i | input | 1 | Transfer engine completion pulse |
| xe_cfg_o | output | 7*DW | Configuration slots, slot k at bits [k*DW +: DW] |
| irq_o | output | 1 | Interrupt, level |

## Verification
The assertions assume three things about the inputs. Memory returns exactly one response for each accepted request, and only after the cycle in which the request was accepted. The transfer engine pulses done only after it has seen a start. Every chain ends with a descriptor that has the end flag set. The bench's memory model answers only a pending request, after a random delay of at least one cycle, and it pulls ready at random. Its engine model answers each start pulse once, after a random delay or after a hold that the bench releases. Every generated chain sets the end flag on its last node.

// File: rtl/dal_pkg.sv
package dal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_PAUSE = 3'd2,
    ST_XFER  = 3'd3,
    ST_DONE  = 3'd4
  } dal_state_e;

  localparam int CFG_SLOTS = 7;
  localparam int WCNT_W    = 4;

  // register addresses
  localparam logic [3:0] RA_CTRL = 4'd0;
  localparam logic [3:0] RA_HEAD = 4'd1;
  localparam logic [3:0] RA_STAT = 4'd2;

  // control word bits
  localparam int CB_START  = 0;
  localparam int CB_RESUME = 1;
  localparam int CB_FMT    = 4;
  localparam int CB_LIST   = 8;
  localparam int CB_FAST   = 10;
  localparam int CB_PMASK  = 12;

  // status bits
  localparam int SB_DIRQ = 4;
  localparam int SB_PIRQ = 5;
  localparam int SB_PTR  = 16;

  // descriptor word 0 bits
  localparam int DB_PAUSE = 0;
  localparam int DB_LINK  = 8;
  localparam int DB_SRCV  = 24;
  localparam int DB_DSTV  = 26;
  localparam int DB_END   = 28;

  function automatic logic [WCNT_W-1:0] desc_words(input logic [1:0] fmt);
    unique case (fmt)
      2'b01:   return 4'd8;
      2'b10:   return 4'd5;
      default: return 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/dal_fetch.sv
module dal_fetch #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] nwords_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          word_vld_o,
  output logic [CW-1:0] word_idx_o,
  output logic [DW-1:0] word_data_o,
  output logic          last_o
);
  logic          active_q, wait_q;
  logic [CW-1:0] idx_q, n_q;
  logic [AW-1:0] base_q;

  assign busy_o      = active_q;
  assign mem_req_o   = active_q & ~wait_q;
  assign mem_addr_o  = base_q + AW'(idx_q);
  assign word_vld_o  = active_q & wait_q & mem_rvalid_i;
  assign word_idx_o  = idx_q;
  assign word_data_o = mem_rdata_i;
  assign last_o      = word_vld_o && (idx_q == n_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      n_q      <= '0;
      base_q   <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      n_q      <= nwords_i;
      base_q   <= base_i;
    end else begin
      if (mem_req_o && mem_ready_i) wait_q <= 1'b1;
      if (word_vld_o) begin
        wait_q <= 1'b0;
        if (last_o) active_q <= 1'b0;
        else        idx_q    <= idx_q + CW'(1);
      end
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));
  assert_rsp_expected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> active_q && wait_q);
  assert_go_when_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !active_q);
endmodule

// File: rtl/dal_cfg_regs.sv
module dal_cfg_regs #(
  parameter int DW = 32,
  parameter int N  = 7,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_we_i,
  input  logic [IW-1:0] sw_idx_i,
  input  logic [DW-1:0] sw_data_i,
  input  logic [N-1:0]  ld_we_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [N*DW-1:0] cfg_o
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q <= '0;
      else if (ld_we_i[k])                         slot_q <= ld_data_i;
      else if (sw_we_i && (int'(sw_idx_i) == k))   slot_q <= sw_data_i;
    end
    assign cfg_o[k*DW +: DW] = slot_q;
  end

  assert_no_dual_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ld_we_i) |-> !sw_we_i);
endmodule

// File: rtl/dal_ctrl.sv
module dal_ctrl
  import dal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int N  = CFG_SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              xe_done_i,
  output logic              xe_start_o,
  output logic              irq_o,
  output logic              fetch_go_o,
  output logic [AW-1:0]     fetch_base_o,
  output logic [WCNT_W-1:0] fetch_nwords_o,
  input  logic              word_vld_i,
  input  logic [WCNT_W-1:0] word_idx_i,
  input  logic [DW-1:0]     word_data_i,
  input  logic              word_last_i,
  output logic [N-1:0]      ld_we_o,
  output logic              cfg_sw_we_o,
  output logic [DW-1:0]     ctl_rd_o,
  output logic [DW-1:0]     head_rd_o,
  output logic [DW-1:0]     stat_rd_o,
  output dal_state_e        state_o
);
  dal_state_e state_q, state_d;
  logic [1:0]    fmt_q;
  logic          list_q, fast_q, pmask_q;
  logic [AW-1:0] head_q, cur_q;
  logic [DW-1:0] w0_q;
  logic          from_desc_q, launched_q, dirq_q, pirq_q;

  logic wr_ctl, wr_head, wr_stat, is_idle, start, resume, xdone;
  logic [WCNT_W-1:0] nw_cur;

  assign wr_ctl  = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_head = reg_we_i && (reg_addr_i == RA_HEAD);
  assign wr_stat = reg_we_i && (reg_addr_i == RA_STAT);
  assign is_idle = (state_q == ST_IDLE);
  assign start   = wr_ctl && is_idle && reg_wdata_i[CB_START];
  assign resume  = wr_ctl && (state_q == ST_PAUSE) && reg_wdata_i[CB_RESUME];
  assign xdone   = (state_q == ST_XFER) && launched_q && xe_done_i;
  assign nw_cur  = desc_words(fmt_q);

  always_comb begin
    state_d        = state_q;
    fetch_go_o     = 1'b0;
    fetch_base_o   = cur_q;
    fetch_nwords_o = start ? desc_words(reg_wdata_i[CB_FMT +: 2]) : nw_cur;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (reg_wdata_i[CB_LIST] && reg_wdata_i[CB_FAST]) begin
          state_d      = ST_FETCH;
          fetch_go_o   = 1'b1;
          fetch_base_o = head_q;
        end else begin
          state_d = ST_XFER;
        end
      end
      ST_FETCH: if (word_last_i) state_d = w0_q[DB_PAUSE] ? ST_PAUSE : ST_XFER;
      ST_PAUSE: if (resume) state_d = ST_XFER;
      ST_XFER: if (xdone) begin
        if (!list_q) begin
          state_d = ST_DONE;
        end else if (!from_desc_q) begin
          state_d      = ST_FETCH;
          fetch_go_o   = 1'b1;
          fetch_base_o = cur_q;
        end else if (w0_q[DB_END]) begin
          state_d = ST_DONE;
        end else begin
          state_d      = ST_FETCH;
          fetch_go_o   = 1'b1;
          fetch_base_o = w0_q[DB_LINK +: AW];
        end
      end
      ST_DONE: if (wr_stat && reg_wdata_i[SB_DIRQ]) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // slot k takes word k+1 if the format carries it and its valid flag allows
  for (genvar k = 0; k < N; k++) begin : g_ld
    assign ld_we_o[k] = word_vld_i && (int'(word_idx_i) == k + 1)
                        && (k + 1 < int'(nw_cur))
                        && (k != 0 || w0_q[DB_SRCV])
                        && (k != 1 || w0_q[DB_DSTV]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fmt_q       <= '0;
      list_q      <= 1'b0;
      fast_q      <= 1'b0;
      pmask_q     <= 1'b0;
      head_q      <= '0;
      cur_q       <= '0;
      w0_q        <= '0;
      from_desc_q <= 1'b0;
      launched_q  <= 1'b0;
      dirq_q      <= 1'b0;
      pirq_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      launched_q <= (state_q == ST_XFER) && (state_d == ST_XFER);
      if (wr_ctl && is_idle) begin
        fmt_q   <= reg_wdata_i[CB_FMT +: 2];
        list_q  <= reg_wdata_i[CB_LIST];
        fast_q  <= reg_wdata_i[CB_FAST];
        pmask_q <= reg_wdata_i[CB_PMASK];
      end
      if (wr_head && is_idle) head_q <= reg_wdata_i[AW-1:0];
      if (start) begin
        cur_q       <= head_q;
        from_desc_q <= 1'b0;
      end
      if (fetch_go_o) begin
        cur_q       <= fetch_base_o;
        from_desc_q <= 1'b1;
      end
      if (word_vld_i && word_idx_i == '0) w0_q <= word_data_i;
      if (state_d == ST_DONE && state_q != ST_DONE)       dirq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[SB_DIRQ])          dirq_q <= 1'b0;
      if (state_d == ST_PAUSE && state_q != ST_PAUSE && pmask_q) pirq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[SB_PIRQ])          pirq_q <= 1'b0;
    end
  end

  assign xe_start_o  = (state_q == ST_XFER) && !launched_q;
  assign irq_o       = dirq_q | pirq_q;
  assign cfg_sw_we_o = reg_we_i && reg_addr_i[3] && is_idle;
  assign state_o     = state_q;

  always_comb begin
    ctl_rd_o                 = '0;
    ctl_rd_o[CB_FMT +: 2]    = fmt_q;
    ctl_rd_o[CB_LIST]        = list_q;
    ctl_rd_o[CB_FAST]        = fast_q;
    ctl_rd_o[CB_PMASK]       = pmask_q;
    head_rd_o                = '0;
    head_rd_o[AW-1:0]        = head_q;
    stat_rd_o                = '0;
    stat_rd_o[2:0]           = state_q;
    stat_rd_o[SB_DIRQ]       = dirq_q;
    stat_rd_o[SB_PIRQ]       = pirq_q;
    stat_rd_o[SB_PTR +: AW]  = cur_q;
  end

  assert_resume_needs_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |=> (state_q == ST_PAUSE) || $past(reg_we_i));
  assert_done_exit_by_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_DONE) || !dirq_q);
  assert_busy_start_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER) && launched_q |=> !xe_start_o);
endmodule

// File: rtl/dma_desc_autoload.sv
module dma_desc_autoload
  import dal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int N  = CFG_SLOTS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [3:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_ready_i,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            xe_start_o,
  input  logic            xe_done_i,
  output logic [N*DW-1:0] xe_cfg_o,
  output logic            irq_o
);
  localparam int IW = 3;

  logic              fetch_go, fetch_busy, word_vld, word_last, cfg_sw_we;
  logic [AW-1:0]     fetch_base;
  logic [WCNT_W-1:0] fetch_nwords, word_idx;
  logic [DW-1:0]     word_data, ctl_rd, head_rd, stat_rd;
  logic [N-1:0]      ld_we;
  dal_state_e        state;

  dal_ctrl #(.AW(AW), .DW(DW), .N(N)) u_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .xe_done_i, .xe_start_o, .irq_o,
    .fetch_go_o(fetch_go), .fetch_base_o(fetch_base), .fetch_nwords_o(fetch_nwords),
    .word_vld_i(word_vld), .word_idx_i(word_idx), .word_data_i(word_data),
    .word_last_i(word_last), .ld_we_o(ld_we), .cfg_sw_we_o(cfg_sw_we),
    .ctl_rd_o(ctl_rd), .head_rd_o(head_rd), .stat_rd_o(stat_rd), .state_o(state)
  );

  dal_fetch #(.AW(AW), .DW(DW), .CW(WCNT_W)) u_fetch (
    .clk_i, .rst_ni, .go_i(fetch_go), .base_i(fetch_base), .nwords_i(fetch_nwords),
    .busy_o(fetch_busy), .mem_req_o, .mem_addr_o, .mem_ready_i, .mem_rvalid_i,
    .mem_rdata_i, .word_vld_o(word_vld), .word_idx_o(word_idx),
    .word_data_o(word_data), .last_o(word_last)
  );

  dal_cfg_regs #(.DW(DW), .N(N), .IW(IW)) u_cfg (
    .clk_i, .rst_ni, .sw_we_i(cfg_sw_we), .sw_idx_i(reg_addr_i[IW-1:0]),
    .sw_data_i(reg_wdata_i), .ld_we_i(ld_we), .ld_data_i(word_data), .cfg_o(xe_cfg_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[3]) begin
      for (int k = 0; k < N; k++)
        if (int'(reg_addr_i[IW-1:0]) == k) reg_rdata_o = xe_cfg_o[k*DW +: DW];
    end else begin
      unique case (reg_addr_i)
        RA_CTRL: reg_rdata_o = ctl_rd;
        RA_HEAD: reg_rdata_o = head_rd;
        RA_STAT: reg_rdata_o = stat_rd;
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assert_start_after_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xe_start_o |-> !fetch_busy && !mem_req_o);
  assert_pause_cfg_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PAUSE) |=> $stable(xe_cfg_o));
  assert_run_cfg_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_XFER) |=> $stable(xe_cfg_o));
  assert_irq_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (state == ST_DONE) || (state == ST_PAUSE));
endmodule

// File: tb/sim_dma_desc_autoload.sv
module sim_dma_desc_autoload;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int N  = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [DW-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic mem_req_o, mem_ready_i, mem_rvalid_i;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata_i;
  logic xe_start_o, xe_done_i, irq_o;
  logic [N*DW-1:0] xe_cfg_o;

  dma_desc_autoload #(.AW(AW), .DW(DW), .N(N)) u0 (.*);

  initial forever #4 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [0:63];
  logic [N*DW-1:0] cap [0:15];
  logic [N*DW-1:0] exp_v [0:15];
  int ncap = 0, nexp = 0, nreads = 0;
  logic [DW-1:0] mcfg [0:N-1];
  logic [AW-1:0] hcur = '0;
  bit eng_hold = 0;
  logic [AW-1:0] paddr [0:7];
  int pidx [0:7];
  int np;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one outstanding read, response at least one cycle later
  initial begin
    bit pend = 0; int rwait = 0; logic [AW-1:0] raddr = '0;
    mem_ready_i = 0; mem_rvalid_i = 0; mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 0;
      if (pend) begin
        if (rwait == 0) begin mem_rvalid_i = 1; mem_rdata_i = mem[raddr[5:0]]; pend = 0; end
        else rwait--;
      end
      mem_ready_i = ($urandom % 3) != 0;
      if (mem_req_o && mem_ready_i && !pend) begin
        pend = 1; raddr = mem_addr_o; rwait = $urandom % 3; nreads++;
      end
    end
  end

  // transfer engine model
  initial begin
    bit ebusy = 0; int ewait = 0;
    xe_done_i = 0;
    forever begin
      @(negedge clk_i);
      xe_done_i = 0;
      if (ebusy) begin
        if (ewait == 0 && !eng_hold) begin xe_done_i = 1; ebusy = 0; end
        else if (ewait > 0) ewait--;
      end
      if (xe_start_o) begin
        if (ncap < 16) cap[ncap] = xe_cfg_o;
        ncap++; ebusy = 1; ewait = $urandom % 4;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk_i); reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  function automatic int nwords(input int fmt);
    return (fmt == 1) ? 8 : (fmt == 2) ? 5 : 3;
  endfunction

  function automatic logic [DW-1:0] ctl(input int mode, input int fmt, input bit pm);
    logic [DW-1:0] c = '0;
    c[5:4] = fmt[1:0];
    c[8]   = (mode != 0);
    c[10]  = (mode == 2);
    c[12]  = pm;
    return c;
  endfunction

  task automatic push_exp();
    for (int k = 0; k < N; k++) exp_v[nexp][k*DW +: DW] = mcfg[k];
    nexp++;
  endtask

  task automatic wait_done(output logic [DW-1:0] s);
    for (int g = 0; g < 3000; g++) begin
      rd(4'd2, s);
      if (s[2:0] == 3'd4) return;
    end
    chk("R10 done reached", s[2:0], 3'd4);
  endtask

  // mode 0 single, 1 list non-fast, 2 list fast
  task automatic run_case(input int mode, input int fmt, input int n, input logic [3:0] pbits, input bit pm);
    logic [DW-1:0] s, w0;
    int sbase, expreads, pk, g;
    string rq;
    for (int k = 0; k < N; k++) begin
      mcfg[k] = $urandom;
      wr(4'd8 + 4'(k), mcfg[k]);
    end
    nexp = 0; np = 0; expreads = 0;
    if (mode != 2) push_exp();
    sbase = $urandom % 8;
    if (mode != 0) begin
      for (int i = 0; i < n; i++) begin
        int a = ((sbase + i) % 8) * 8;
        int nx = ((sbase + i + 1) % 8) * 8;
        bit sv = $urandom % 4 != 0, dv = $urandom % 4 != 0;
        w0 = '0;
        w0[0] = pbits[i]; w0[23:8] = 16'(nx); w0[24] = sv; w0[26] = dv; w0[28] = (i == n - 1);
        w0[7:1] = 7'($urandom);
        mem[a] = w0;
        for (int k = 1; k < 8; k++) mem[a + k] = $urandom;
        for (int k = 0; k < N; k++)
          if (k + 1 < nwords(fmt) && (k != 0 || sv) && (k != 1 || dv)) mcfg[k] = mem[a + k + 1];
        if (pbits[i]) begin paddr[np] = 16'(a); pidx[np] = nexp; np++; end
        push_exp();
        expreads += nwords(fmt);
      end
      hcur = 16'(sbase * 8);
      wr(4'd1, {16'h0, hcur});
    end
    ncap = 0; nreads = 0; pk = 0;
    wr(4'd0, ctl(mode, fmt, pm) | 32'h1);
    for (g = 0; g < 3000; g++) begin
      rd(4'd2, s);
      if (s[2:0] == 3'd4) break;
      if (s[2:0] == 3'd2) begin
        if (pk < np) begin
          chk("R13 paused descriptor address", s[31:16], paddr[pk]);
          chk("R8 transfers before pause", ncap, pidx[pk]);
          for (int k = 0; k < N; k++)
            chk("R9 loaded slots held in pause", xe_cfg_o[k*DW +: DW], exp_v[pidx[pk]][k*DW +: DW]);
        end
        chk("R11 pause irq follows mask", irq_o, pm);
        if (pm) begin
          wr(4'd2, 32'h20);
          chk("R11 pause irq cleared", irq_o, 0);
        end
        wr(4'd0, 32'h2);
        pk++;
      end
    end
    if (g >= 3000) chk("R10 done reached", s[2:0], 3'd4);
    chk("R8 pause count", pk, np);
    chk("R10 done status bit", s[4], 1);
    chk("R10 irq at end", irq_o, 1);
    rq = (mode == 0) ? "R2 transfer count" : (mode == 1) ? "R3 transfer count" : "R7 transfer count";
    chk(rq, ncap, nexp);
    chk("R5 descriptor words read", nreads, expreads);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      rq = (i == 0 && mode == 2) ? "R4 first transfer loaded" :
           (i == 0) ? "R3 first transfer preset" : "R6 slot values";
      for (int k = 0; k < N; k++) chk(rq, cap[i][k*DW +: DW], exp_v[i][k*DW +: DW]);
    end
    wr(4'd2, 32'h10);
    rd(4'd2, s);
    chk("R10 clear returns idle", s[2:0], 3'd0);
    chk("R10 irq cleared", irq_o, 0);
  endtask

  initial begin
    logic [DW-1:0] s, a0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
    rd(4'd2, s);
    chk("R1 reset status", s, 32'h0);
    chk("R1 reset irq", irq_o, 0);
    chk("R1 reset mem_req", mem_req_o, 0);
    chk("R1 reset start", xe_start_o, 0);

    // resume in idle is ignored
    ncap = 0;
    wr(4'd0, 32'h2);
    rd(4'd2, s);
    chk("R8 resume ignored in idle", s[2:0], 3'd0);
    chk("R8 no transfer from resume", ncap, 0);

    // directed corner cases
    run_case(0, 1, 1, 4'b0000, 0);
    run_case(2, 1, 3, 4'b0001, 1);
    run_case(1, 2, 2, 4'b0010, 0);
    run_case(2, 3, 4, 4'b1010, 1);
    run_case(1, 0, 1, 4'b0001, 1);

    // writes while busy are ignored
    a0 = 32'hA5A5_0001;
    wr(4'd8, a0);
    eng_hold = 1; ncap = 0;
    wr(4'd0, 32'h1);
    for (int g = 0; g < 50; g++) begin rd(4'd2, s); if (s[2:0] == 3'd3) break; end
    chk("R13 transfer state code", s[2:0], 3'd3);
    wr(4'd0, ctl(2, 1, 1) | 32'h1);
    wr(4'd8, 32'h1234_5678);
    wr(4'd1, 32'h30);
    rd(4'd0, s);
    chk("R12 control fields unchanged", s, 32'h0);
    rd(4'd8, s);
    chk("R12 slot write ignored", s, a0);
    rd(4'd1, s);
    chk("R12 head write ignored", s, {16'h0, hcur});
    chk("R12 no extra start", ncap, 1);
    eng_hold = 0;
    wait_done(s);
    chk("R2 single transfer", ncap, 1);
    wr(4'd2, 32'h10);

    // constrained random mix
    for (int t = 0; t < 24; t++) begin
      int md = $urandom % 3;
      int ft = $urandom % 4;
      int nn = 1 + $urandom % 4;
      logic [3:0] pb;
      for (int b = 0; b < 4; b++) pb[b] = ($urandom % 3) == 0;
      run_case(md, ft, nn, pb, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule